// File: doc/BRIEF.md
# Dual-Clock FIFO with Double-Synchronized Status Flags

This block is a first-in first-out buffer whose write port and read port run on two unrelated clocks. Words enter on the write clock while the write side watches a `full` flag. They leave on the read clock while the read side watches a `data_ready` flag. Each flag is a register in the clock domain of the port that uses it. The position of the opposite port reaches that domain as a Gray-coded pointer, which passes through a chain of at least two flip-flops. The metastability window of the first stage therefore has a whole period to resolve before any flag logic sees it.

A static mode input picks one of two read behaviours. In fall-through mode the oldest word is already on `rd_data` in the cycle in which `data_ready` rises, and each read-enable strobe moves to the next word. In standard mode `data_ready` rises first, and a word is put on `rd_data` only by the read clock edge that samples `rd_enable` high while `data_ready` is high. In both modes `rd_data` is a holding register: it keeps its value until the reader acts. The mode is expected to stay constant between resets.

Top module: `xclk_fifo`

## Requirements
- R1: Words leave through `rd_data` in exactly the order in which they were accepted on the write port, in both modes and with both ports active at once.
- R2: With no reads, `full` is low after DEPTH-1 accepted writes. In standard mode it is high after DEPTH accepted writes. It rises only on a write-clock edge that follows a cycle with `wr_enable` high.
- R3: A write attempted while `full` is high is dropped. The write pointer does not move, and the word never appears at the read port.
- R4: A read strobe while `data_ready` is low is ignored. `rd_data` keeps its value, and the next word read out is the oldest word written afterwards.
- R5: With `fwft_mode` = 1, the oldest word is present on `rd_data` in the same read cycle in which `data_ready` first reads high.
- R6: With `fwft_mode` = 0, `rd_data` keeps its previous value while `data_ready` is high and no read has been made. The word appears on `rd_data` after the read-clock edge that sees `rd_enable` = 1 and `data_ready` = 1.
- R7: While `data_ready` is high and `rd_enable` is low, `rd_data` does not change.
- R8: Each pointer passed across domains is Gray-coded and changes in at most one bit per clock of its own domain.
- R9: The synchronizers add only a bounded delay. `data_ready` rises within 6 read clocks of a write into an empty FIFO, and `full` falls within 6 write clocks of a read from a full FIFO.
- R10: After reset, `full` = 0, `data_ready` = 0 and `rd_data` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-port clock |
| wr_rst_n | input | 1 | Active-low asynchronous reset of the write domain |
| wr_enable | input | 1 | Write strobe, sampled on the rising edge of `wr_clk` |
| wr_data | input | WIDTH | Word to store |
| full | output | 1 | No free slot (registered on `wr_clk`) |
| rd_clk | input | 1 | Read-port clock |
| rd_rst_n | input | 1 | Active-low asynchronous reset of the read domain |
| rd_enable | input | 1 | Read strobe, sampled on the rising edge of `rd_clk` |
| rd_data | output | WIDTH | Output holding register |
| data_ready | output | 1 | A word is available to the reader (registered on `rd_clk`) |
| fwft_mode | input | 1 | 1 = fall-through output, 0 = standard output; held static between resets |

## Verification
The buffer's ordering is exercised in three ways. Isolated single writes with reads show when a word becomes visible, which separates the fall-through timing from the standard timing. Back-to-back bursts that fill the memory exercise the wraparound of the full comparison and the dropping of extra writes. Concurrent writing and reading at skewed clock phases make the pointers cross domains while both are moving, so a wrong Gray conversion or a wrong comparison shows up as a missing or repeated word. Idle gaps with the read strobe held high, or with the strobe low while data waits, show whether the output register holds its value correctly.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

   typedef enum logic {
      XF_STANDARD = 1'b0,
      XF_FALLTHRU = 1'b1
   } xf_mode_e;

   localparam int XF_MAX_PTR_W = 32;

   function automatic logic [XF_MAX_PTR_W-1:0] xf_to_gray(input logic [XF_MAX_PTR_W-1:0] b);
      return b ^ (b >> 1);
   endfunction

endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/xfifo_mem.sv
module xfifo_mem #(
   parameter int WIDTH  = 8,
   parameter int ADDR_W = 3
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WIDTH-1:0]  wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WIDTH-1:0]  rdata
);
   localparam int SLOTS = 1 << ADDR_W;

   logic [WIDTH-1:0] store [SLOTS];

   always_ff @(posedge wclk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];
endmodule

// File: rtl/xfifo_wptr.sv
module xfifo_wptr
   import xfifo_pkg::*;
#(
   parameter int PW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_enable,
   input  logic [PW-1:0] rgray_sync,
   output logic [PW-1:0] wbin,
   output logic [PW-1:0] wgray,
   output logic          full,
   output logic          accept
);
   logic [PW-1:0] wbin_nx;
   logic [PW-1:0] wgray_nx;
   logic [PW-1:0] wrapped_rd;

   assign accept     = wr_enable & ~full;
   assign wbin_nx    = wbin + PW'(accept);
   assign wgray_nx   = PW'(xf_to_gray(XF_MAX_PTR_W'(wbin_nx)));
   // In Gray code, "one lap ahead" shows as the two top bits inverted
   assign wrapped_rd = {~rgray_sync[PW-1:PW-2], rgray_sync[PW-3:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
         full  <= 1'b0;
      end else begin
         wbin  <= wbin_nx;
         wgray <= wgray_nx;
         full  <= (wgray_nx == wrapped_rd);
      end
   end
endmodule

// File: rtl/xfifo_rptr.sv
module xfifo_rptr
   import xfifo_pkg::*;
#(
   parameter int PW    = 4,
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_enable,
   input  logic             fwft,
   input  logic [PW-1:0]    wgray_sync,
   input  logic [WIDTH-1:0] mem_word,
   output logic [PW-1:0]    rbin,
   output logic [PW-1:0]    rgray,
   output logic [WIDTH-1:0] rd_data,
   output logic             data_ready
);
   logic          mem_empty;
   logic          hold_vld;
   logic          fetch;
   logic [PW-1:0] rbin_nx;
   logic [PW-1:0] rgray_nx;
   logic          hold_vld_nx;

   always_comb begin
      if (fwft == XF_FALLTHRU) begin
         fetch       = ~mem_empty & (~hold_vld | rd_enable);
         hold_vld_nx = fetch | (hold_vld & ~rd_enable);
         data_ready  = hold_vld;
      end else begin
         fetch       = ~mem_empty & rd_enable;
         hold_vld_nx = 1'b0;
         data_ready  = ~mem_empty;
      end
   end

   assign rbin_nx  = rbin + PW'(fetch);
   assign rgray_nx = PW'(xf_to_gray(XF_MAX_PTR_W'(rbin_nx)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin      <= '0;
         rgray     <= '0;
         mem_empty <= 1'b1;
         hold_vld  <= 1'b0;
         rd_data   <= '0;
      end else begin
         rbin      <= rbin_nx;
         rgray     <= rgray_nx;
         mem_empty <= (rgray_nx == wgray_sync);
         hold_vld  <= hold_vld_nx;
         if (fetch) rd_data <= mem_word;
      end
   end
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
   import xfifo_pkg::*;
#(
   parameter int WIDTH       = 16,
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             wr_clk,
   input  logic             wr_rst_n,
   input  logic             wr_enable,
   input  logic [WIDTH-1:0] wr_data,
   output logic             full,
   input  logic             rd_clk,
   input  logic             rd_rst_n,
   input  logic             rd_enable,
   output logic [WIDTH-1:0] rd_data,
   output logic             data_ready,
   input  logic             fwft_mode
);
   localparam int ADDR_W = $clog2(DEPTH);
   localparam int PTR_W  = ADDR_W + 1;

   generate
      if (DEPTH < 4 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
         $error("xclk_fifo: DEPTH must be a power of two and at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("xclk_fifo: SYNC_STAGES must be at least 2");
      end
      if (PTR_W > XF_MAX_PTR_W) begin : g_bad_ptr
         $error("xclk_fifo: DEPTH too large for pointer helper");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("xclk_fifo: WIDTH must be positive");
      end
   endgenerate

   logic [PTR_W-1:0] w_ptr_bin;
   logic [PTR_W-1:0] w_ptr_gray;
   logic [PTR_W-1:0] r_ptr_bin;
   logic [PTR_W-1:0] r_ptr_gray;
   logic [PTR_W-1:0] wgray_in_rd;
   logic [PTR_W-1:0] rgray_in_wr;
   logic             wr_accept;
   logic [WIDTH-1:0] mem_word;

   xfifo_wptr #(.PW(PTR_W)) u_wptr (
      .clk        (wr_clk),
      .rst_n      (wr_rst_n),
      .wr_enable  (wr_enable),
      .rgray_sync (rgray_in_wr),
      .wbin       (w_ptr_bin),
      .wgray      (w_ptr_gray),
      .full       (full),
      .accept     (wr_accept)
   );

   xfifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_r2w (
      .clk   (wr_clk),
      .rst_n (wr_rst_n),
      .d     (r_ptr_gray),
      .q     (rgray_in_wr)
   );

   xfifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_w2r (
      .clk   (rd_clk),
      .rst_n (rd_rst_n),
      .d     (w_ptr_gray),
      .q     (wgray_in_rd)
   );

   xfifo_mem #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_mem (
      .wclk  (wr_clk),
      .we    (wr_accept),
      .waddr (w_ptr_bin[ADDR_W-1:0]),
      .wdata (wr_data),
      .raddr (r_ptr_bin[ADDR_W-1:0]),
      .rdata (mem_word)
   );

   xfifo_rptr #(.PW(PTR_W), .WIDTH(WIDTH)) u_rptr (
      .clk        (rd_clk),
      .rst_n      (rd_rst_n),
      .rd_enable  (rd_enable),
      .fwft       (fwft_mode),
      .wgray_sync (wgray_in_rd),
      .mem_word   (mem_word),
      .rbin       (r_ptr_bin),
      .rgray      (r_ptr_gray),
      .rd_data    (rd_data),
      .data_ready (data_ready)
   );
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
   parameter int PW = 4,
   parameter int DW = 8
) (
   input logic          wr_clk,
   input logic          wr_rst_n,
   input logic          wr_enable,
   input logic          full,
   input logic          rd_clk,
   input logic          rd_rst_n,
   input logic          rd_enable,
   input logic          data_ready,
   input logic [DW-1:0] rd_data,
   input logic          fwft_mode,
   input logic [PW-1:0] w_ptr_bin,
   input logic [PW-1:0] w_ptr_gray,
   input logic [PW-1:0] r_ptr_bin,
   input logic [PW-1:0] r_ptr_gray
);
   a_r3_drop_when_full: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (wr_enable && full) |=> $stable(w_ptr_bin));

   a_r2_full_follows_write: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      $rose(full) |-> $past(wr_enable));

   a_r4_ignore_read_not_ready: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (!fwft_mode && rd_enable && !data_ready) |=> $stable(r_ptr_bin));

   a_r7_hold_output: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (!rd_enable && data_ready) |=> $stable(rd_data));

   a_r8_wr_gray_step: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      $countones(w_ptr_gray ^ $past(w_ptr_gray)) <= 1);

   a_r8_rd_gray_step: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      $countones(r_ptr_gray ^ $past(r_ptr_gray)) <= 1);
endmodule

bind xclk_fifo xclk_fifo_chk #(.PW(PTR_W), .DW(WIDTH)) u_chk (.*);

// File: tb/xclk_fifo_tb_top.sv
module xclk_fifo_tb_top;
   localparam int W = 8;
   localparam int D = 8;

   logic         wr_clk = 1'b0;
   logic         rd_clk = 1'b0;
   logic         wr_rst_n, rd_rst_n;
   logic         wr_enable, rd_enable, fwft_mode;
   logic [W-1:0] wr_data;
   logic [W-1:0] rd_data;
   logic         full, data_ready;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #10 wr_clk = ~wr_clk;
   initial begin
      #3;
      forever #10 rd_clk = ~rd_clk;
   end

   xclk_fifo #(.WIDTH(W), .DEPTH(D), .SYNC_STAGES(2)) dut_i (
      .wr_clk     (wr_clk),
      .wr_rst_n   (wr_rst_n),
      .wr_enable  (wr_enable),
      .wr_data    (wr_data),
      .full       (full),
      .rd_clk     (rd_clk),
      .rd_rst_n   (rd_rst_n),
      .rd_enable  (rd_enable),
      .rd_data    (rd_data),
      .data_ready (data_ready),
      .fwft_mode  (fwft_mode)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset(input bit fw);
      fwft_mode = fw;
      wr_enable = 0; rd_enable = 0; wr_data = '0;
      wr_rst_n  = 0; rd_rst_n  = 0;
      repeat (4) @(negedge wr_clk);
      wr_rst_n = 1; rd_rst_n = 1;
      repeat (2) @(negedge rd_clk);
   endtask

   task automatic push(input logic [W-1:0] d);
      @(negedge wr_clk);
      wr_enable = 1; wr_data = d;
      @(negedge wr_clk);
      wr_enable = 0;
   endtask

   task automatic wait_ready(output bit got, output int cycles);
      got = 0; cycles = 0;
      for (int i = 1; i <= 12; i++) begin
         @(negedge rd_clk);
         if (data_ready) begin got = 1; cycles = i; break; end
      end
   endtask

   task automatic pop(input logic [W-1:0] exp, input string req);
      bit got; int cyc;
      wait_ready(got, cyc);
      chk(got, req, int'(data_ready), 1);
      if (got) begin
         if (fwft_mode) begin
            chk(rd_data == exp, req, int'(rd_data), int'(exp));
            rd_enable = 1;
            @(negedge rd_clk);
            rd_enable = 0;
         end else begin
            rd_enable = 1;
            @(negedge rd_clk);
            rd_enable = 0;
            chk(rd_data == exp, req, int'(rd_data), int'(exp));
         end
      end
   endtask

   function automatic logic [W-1:0] pat(input int i);
      return W'(i * 37 + 11);
   endfunction

   task automatic t_reset_state();
      do_reset(1'b0);
      chk(full == 1'b0, "R10 full", int'(full), 0);
      chk(data_ready == 1'b0, "R10 data_ready", int'(data_ready), 0);
      chk(rd_data == '0, "R10 rd_data", int'(rd_data), 0);
   endtask

   task automatic t_fwft_first();
      bit got; int cyc;
      do_reset(1'b1);
      push(8'hC3);
      wait_ready(got, cyc);
      chk(got, "R5 ready", int'(got), 1);
      chk(rd_data == 8'hC3, "R5 first word with ready", int'(rd_data), 'hC3);
      chk(cyc <= 6, "R9 ready latency fwft", cyc, 6);
      rd_enable = 1; @(negedge rd_clk); rd_enable = 0;
      repeat (3) @(negedge rd_clk);
      chk(data_ready == 1'b0, "R4 drained", int'(data_ready), 0);
   endtask

   task automatic t_std_first();
      bit got; int cyc;
      do_reset(1'b0);
      push(8'hA5);
      wait_ready(got, cyc);
      chk(got, "R6 ready", int'(got), 1);
      chk(cyc <= 6, "R9 ready latency std", cyc, 6);
      chk(rd_data == 8'h00, "R6 no word before read", int'(rd_data), 0);
      rd_enable = 1; @(negedge rd_clk); rd_enable = 0;
      chk(rd_data == 8'hA5, "R6 word after read", int'(rd_data), 'hA5);
      push(8'h3C);
      wait_ready(got, cyc);
      chk(rd_data == 8'hA5, "R6 previous word held", int'(rd_data), 'hA5);
      rd_enable = 1; @(negedge rd_clk); rd_enable = 0;
      chk(rd_data == 8'h3C, "R6 second word", int'(rd_data), 'h3C);
   endtask

   task automatic t_read_empty();
      do_reset(1'b0);
      rd_enable = 1;
      repeat (4) @(negedge rd_clk);
      rd_enable = 0;
      chk(data_ready == 1'b0, "R4 still empty", int'(data_ready), 0);
      chk(rd_data == '0, "R4 rd_data untouched", int'(rd_data), 0);
      push(8'h5A);
      pop(8'h5A, "R4 next word after empty reads");
   endtask

   task automatic t_hold();
      bit got; int cyc;
      do_reset(1'b1);
      push(8'h11);
      push(8'h22);
      wait_ready(got, cyc);
      repeat (6) @(negedge rd_clk);
      chk(rd_data == 8'h11, "R7 held while idle", int'(rd_data), 'h11);
      chk(data_ready == 1'b1, "R7 ready held", int'(data_ready), 1);
      pop(8'h11, "R1 hold order");
      pop(8'h22, "R1 hold order");
   endtask

   task automatic t_fill();
      bit dropped; int cyc;
      do_reset(1'b0);
      @(negedge wr_clk);
      for (int i = 0; i < D; i++) begin
         wr_enable = 1; wr_data = pat(i);
         @(negedge wr_clk);
         if (i == D - 2) chk(full == 1'b0, "R2 not full at DEPTH-1", int'(full), 0);
      end
      wr_enable = 0;
      chk(full == 1'b1, "R2 full at DEPTH", int'(full), 1);
      wr_enable = 1; wr_data = 8'hEE;
      @(negedge wr_clk);
      wr_enable = 0;
      chk(full == 1'b1, "R3 full after dropped write", int'(full), 1);
      pop(pat(0), "R1 fill order");
      cyc = 0;
      for (int i = 1; i <= 12; i++) begin
         @(negedge wr_clk);
         if (!full) begin cyc = i; break; end
      end
      chk(cyc != 0 && cyc <= 6, "R9 full release latency", cyc, 6);
      for (int i = 1; i < D; i++) pop(pat(i), "R1 fill order");
      repeat (8) @(negedge rd_clk);
      dropped = !data_ready;
      chk(dropped, "R3 extra word absent", int'(data_ready), 0);
   endtask

   task automatic t_stream(input bit fw);
      do_reset(fw);
      fork
         begin
            for (int i = 0; i < 40; i++) begin
               @(negedge wr_clk);
               while (full) begin wr_enable = 0; @(negedge wr_clk); end
               wr_enable = 1; wr_data = pat(i + 100);
            end
            @(negedge wr_clk);
            wr_enable = 0;
         end
         begin
            for (int i = 0; i < 40; i++)
               pop(pat(i + 100), fw ? "R1 stream fwft" : "R1 stream std");
         end
      join
   endtask

   initial begin
      t_reset_state();
      t_fwft_first();
      t_std_first();
      t_read_empty();
      t_hold();
      t_fill();
      t_stream(1'b0);
      t_stream(1'b1);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule